// File: doc/BRIEF.md
# Keyed Windowed Watchdog Timer

This block guards a processor against lost program control. Software must service it by writing an 8-bit service word, and the write only counts when it carries the correct key and lands inside a time window. The window opens after a fixed minimum number of idle-timer ticks and closes at an upper limit chosen by a field in the service word. Time is measured only on core-clock cycles where the `tick` enable is high, so the window scales with the idle timer and not with the core clock.

Three events cause a one-cycle reset request. The first is a write with a wrong key. The second is a correctly keyed write that arrives too early, which catches a runaway loop that keeps executing the service write. The third is the count reaching the selected upper limit with no service. An accepted write restarts the count and loads the window select and the clock-monitor select bit. Both stay visible on output ports. The clock-monitor select bit is only stored here, for a separate clock-absence detector to use.

Top module: `keyed_window_wdt`

## Requirements
- R1: After reset the reset request is low, the window select reads 2'b00, the clock-monitor select reads 0 and the tick count is zero.
- R2: The service word is decoded as: bits 7:6 = window select, bits 5:1 = key, bit 0 = clock-monitor select. A write is correctly keyed only when bits 5:1 equal 5'b01100.
- R3: The tick count advances by one only on core-clock cycles with `tick` high. Cycles with `tick` low do not change it.
- R4: A correctly keyed write made while the count is below LOWER_TICKS (default 2048) raises the reset request. The window select and the clock-monitor select stay unchanged.
- R5: A write with any other key raises the reset request, whatever the count. The window select and the clock-monitor select stay unchanged.
- R6: A correctly keyed write made with LOWER_TICKS ≤ count < upper limit raises no request. It loads the window select from bits 7:6 and the clock-monitor select from bit 0.
- R7: The upper limit is UPPER_BASE shifted left by the window select. With the default UPPER_BASE of 8192, select 00, 01, 10 and 11 give 8192, 16384, 32768 and 65536 ticks.
- R8: With no write, the tick that would bring the count to the upper limit raises the reset request, and the count returns to zero.
- R9: Every write, accepted or rejected, restarts the count at zero. After any reset request the next window starts from zero.
- R10: When a write and a tick occur in the same cycle, the write decides the outcome using the count before that tick, and the tick is not counted.
- R11: The reset request is registered. It is high only in the cycle after the event that caused it, for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Idle-timer tick enable, one count per high cycle |
| svc_wr | input | 1 | Service-register write strobe |
| svc_data | input | 8 | Service word written with `svc_wr` |
| win_sel_o | output | 2 | Current window select |
| cm_sel_o | output | 1 | Stored clock-monitor select bit |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with LOWER_TICKS = 16 and UPPER_BASE = 64, which gives upper limits of 64, 128, 256 and 512 ticks. At these values every window select can be driven to expiry, and the exact last tick of each window can be hit, in a few thousand cycles. The lower boundary is probed one tick either side of 16. Gated tick patterns, with several idle core cycles between ticks, show that only ticks count. A write that coincides with a tick at the last legal count shows which of the two takes precedence.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Width of the window-select field, fixed by the service-word layout.
   localparam int SEL_W = 2;

   // Key value that a service word must carry in its key field.
   localparam logic [4:0] SVC_KEY = 5'b01100;

   // Service word layout, most significant field first.
   typedef struct packed {
      logic [SEL_W-1:0] win;
      logic [4:0]       key;
      logic             cm;
   } svc_word_t;

   // Cause of a reset request.
   typedef enum logic [1:0] {
      TRIP_NONE  = 2'd0,
      TRIP_EARLY = 2'd1,
      TRIP_KEY   = 2'd2,
      TRIP_LATE  = 2'd3
   } trip_e;

endpackage

// File: rtl/wdt_svc_decode.sv
module wdt_svc_decode
   import wdt_pkg::*;
(
   input  logic [7:0]       svc_data,
   output logic             key_ok,
   output logic [SEL_W-1:0] win_new,
   output logic             cm_new
);

   svc_word_t word;

   assign word    = svc_word_t'(svc_data);
   assign key_ok  = (word.key == SVC_KEY);
   assign win_new = word.win;
   assign cm_new  = word.cm;

endmodule

// File: rtl/wdt_window_ctr.sv
module wdt_window_ctr #(
   parameter int LOWER_TICKS = 2048,
   parameter int UPPER_BASE  = 8192,
   parameter int NSEL        = 4,
   parameter int SEL_W       = 2,
   parameter int CNT_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [SEL_W-1:0] win_sel,
   output logic             below_lower,
   output logic             expire
);

   localparam logic [CNT_W-1:0] LOW_CMP = CNT_W'(LOWER_TICKS);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   lim_tab [NSEL];
   logic [CNT_W:0]   cur_lim;
   logic [CNT_W:0]   cur_last;
   logic             at_last;

   // One upper limit per window select, each double the one before.
   for (genvar g = 0; g < NSEL; g++) begin : g_lim
      assign lim_tab[g] = (CNT_W+1)'(UPPER_BASE) << g;
   end

   assign cur_lim     = lim_tab[win_sel];
   assign cur_last    = cur_lim - (CNT_W+1)'(1);
   assign at_last     = ({1'b0, cnt_q} == cur_last);
   assign expire      = tick & at_last;
   assign below_lower = (cnt_q < LOW_CMP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   // R7
   cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cnt_q} < cur_lim);

   // R3
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !restart) |=> $stable(cnt_q));

   // R9
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_policy.sv
module wdt_policy
   import wdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             svc_wr,
   input  logic             key_ok,
   input  logic [SEL_W-1:0] win_new,
   input  logic             cm_new,
   input  logic             below_lower,
   input  logic             expire,
   output logic             restart,
   output logic [SEL_W-1:0] win_q,
   output logic             cm_q,
   output logic             rst_req_q
);

   trip_e trip;
   logic  accept;

   // A write takes precedence over a tick in the same cycle.
   always_comb begin
      trip   = TRIP_NONE;
      accept = 1'b0;
      if (svc_wr) begin
         if (!key_ok)          trip = TRIP_KEY;
         else if (below_lower) trip = TRIP_EARLY;
         else                  accept = 1'b1;
      end else if (expire) begin
         trip = TRIP_LATE;
      end
   end

   assign restart = svc_wr | expire;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q     <= '0;
         cm_q      <= 1'b0;
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= (trip != TRIP_NONE);
         if (accept) begin
            win_q <= win_new;
            cm_q  <= cm_new;
         end
      end
   end

   // R5
   key_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_wr && !key_ok) |=> rst_req_q);

   // R4
   early_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_wr && key_ok && below_lower) |=> rst_req_q);

   // R8
   late_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !svc_wr) |=> rst_req_q);

   // R6
   accept_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_wr && key_ok && !below_lower) |=>
         (!rst_req_q && win_q == $past(win_new) && cm_q == $past(cm_new)));

   // R5
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(svc_wr && key_ok && !below_lower) |=> ($stable(win_q) && $stable(cm_q)));

   // R11
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!svc_wr && !expire) |=> !rst_req_q);

endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt
   import wdt_pkg::*;
#(
   parameter int LOWER_TICKS = 2048,
   parameter int UPPER_BASE  = 8192
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             svc_wr,
   input  logic [7:0]       svc_data,
   output logic [SEL_W-1:0] win_sel_o,
   output logic             cm_sel_o,
   output logic             rst_req_o
);

   localparam int NSEL  = 1 << SEL_W;
   localparam int CNT_W = $clog2(UPPER_BASE << (NSEL - 1));

   initial begin
      lower_pos_chk: assert (LOWER_TICKS > 0)
         else $error("LOWER_TICKS must be positive");
      lower_below_upper_chk: assert (LOWER_TICKS < UPPER_BASE)
         else $error("LOWER_TICKS must be below UPPER_BASE");
   end

   logic             key_ok;
   logic [SEL_W-1:0] win_new;
   logic             cm_new;
   logic             below_lower;
   logic             expire;
   logic             restart;

   wdt_svc_decode u_dec (
      .svc_data (svc_data),
      .key_ok   (key_ok),
      .win_new  (win_new),
      .cm_new   (cm_new)
   );

   wdt_window_ctr #(
      .LOWER_TICKS (LOWER_TICKS),
      .UPPER_BASE  (UPPER_BASE),
      .NSEL        (NSEL),
      .SEL_W       (SEL_W),
      .CNT_W       (CNT_W)
   ) u_ctr (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .restart     (restart),
      .win_sel     (win_sel_o),
      .below_lower (below_lower),
      .expire      (expire)
   );

   wdt_policy u_pol (
      .clk         (clk),
      .rst_n       (rst_n),
      .svc_wr      (svc_wr),
      .key_ok      (key_ok),
      .win_new     (win_new),
      .cm_new      (cm_new),
      .below_lower (below_lower),
      .expire      (expire),
      .restart     (restart),
      .win_q       (win_sel_o),
      .cm_q        (cm_sel_o),
      .rst_req_q   (rst_req_o)
   );

endmodule

// File: tb/sim_keyed_window_wdt.sv
`timescale 1ns/1ps
module sim_keyed_window_wdt;

   localparam int LOW  = 16;
   localparam int BASE = 64;
   localparam logic [4:0] KEY = 5'b01100;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic       svc_wr;
   logic [7:0] svc_data;
   logic [1:0] win_sel_o;
   logic       cm_sel_o;
   logic       rst_req_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   keyed_window_wdt #(.LOWER_TICKS(LOW), .UPPER_BASE(BASE)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .svc_wr    (svc_wr),
      .svc_data  (svc_data),
      .win_sel_o (win_sel_o),
      .cm_sel_o  (cm_sel_o),
      .rst_req_o (rst_req_o)
   );

   function automatic logic [7:0] mkword(logic [1:0] w, logic c, logic [4:0] k);
      return {w, k, c};
   endfunction

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 1'b0; svc_wr = 1'b0; svc_data = '0;
      cyc(); cyc();
      rst_n = 1'b1;
   endtask

   // n ticks on consecutive cycles, no request expected meanwhile
   task automatic run_ticks(int n);
      tick = 1'b1;
      for (int i = 0; i < n; i++) begin
         cyc();
         if (rst_req_o !== 1'b0) chk("R8 no request before limit", rst_req_o, 0);
      end
      tick = 1'b0;
   endtask

   task automatic svc(logic [7:0] d, logic t);
      svc_wr = 1'b1; svc_data = d; tick = t;
      cyc();
      svc_wr = 1'b0; tick = 1'b0;
   endtask

   // request high now, low one cycle later
   task automatic expect_pulse(string tag);
      chk({tag, " request"}, rst_req_o, 1);
      cyc();
      chk("R11 single-cycle request", rst_req_o, 0);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 request low", rst_req_o, 0);
      chk("R1 window select", win_sel_o, 0);
      chk("R1 monitor select", cm_sel_o, 0);
   endtask

   task automatic t_early();
      do_reset();
      run_ticks(LOW - 1);
      svc(mkword(2'b10, 1'b1, KEY), 1'b0);
      expect_pulse("R4 early write");
      chk("R4 window unchanged", win_sel_o, 0);
      chk("R4 monitor unchanged", cm_sel_o, 0);
   endtask

   task automatic t_lower_edge();
      do_reset();
      run_ticks(LOW);
      svc(mkword(2'b01, 1'b1, KEY), 1'b0);
      chk("R6 no request at lower limit", rst_req_o, 0);
      chk("R2 R6 window loaded", win_sel_o, 1);
      chk("R2 R6 monitor loaded", cm_sel_o, 1);
      // R9: counter restarted, so LOW-1 more ticks is early again
      run_ticks(LOW - 1);
      svc(mkword(2'b00, 1'b0, KEY), 1'b0);
      expect_pulse("R9 restart then early");
      chk("R4 window kept after early", win_sel_o, 1);
   endtask

   task automatic t_badkey();
      logic [4:0] bad [3] = '{5'b01101, 5'b11100, 5'b00000};
      do_reset();
      for (int i = 0; i < 3; i++) begin
         run_ticks(LOW + 2);
         svc(mkword(2'b11, 1'b1, bad[i]), 1'b0);
         expect_pulse("R5 wrong key");
         chk("R5 window unchanged", win_sel_o, 0);
         chk("R5 monitor unchanged", cm_sel_o, 0);
      end
      // R5 even before the lower limit
      svc(mkword(2'b00, 1'b0, 5'b11111), 1'b0);
      expect_pulse("R5 wrong key at zero count");
   endtask

   task automatic t_late();
      do_reset();
      run_ticks(BASE - 1);
      tick = 1'b1; cyc(); tick = 1'b0;
      expect_pulse("R8 expiry select 00");
      // R9: after the trip the count starts from zero
      run_ticks(LOW - 1);
      svc(mkword(2'b00, 1'b0, KEY), 1'b0);
      expect_pulse("R9 window after expiry");
   endtask

   task automatic t_sel(logic [1:0] s);
      do_reset();
      run_ticks(LOW);
      svc(mkword(s, 1'b0, KEY), 1'b0);
      chk("R6 accepted before limit test", rst_req_o, 0);
      chk("R7 select loaded", win_sel_o, s);
      run_ticks((BASE << s) - 1);
      tick = 1'b1; cyc(); tick = 1'b0;
      expect_pulse("R7 expiry at selected limit");
   endtask

   task automatic t_last();
      do_reset();
      run_ticks(BASE - 1);
      svc(mkword(2'b10, 1'b0, KEY), 1'b1);
      chk("R10 write wins over final tick", rst_req_o, 0);
      chk("R6 window loaded at last count", win_sel_o, 2);
      // R10: the simultaneous tick was not counted
      run_ticks(LOW - 1);
      svc(mkword(2'b10, 1'b0, KEY), 1'b0);
      expect_pulse("R10 tick not counted");
      do_reset();
      run_ticks(LOW - 1);
      svc(mkword(2'b01, 1'b0, KEY), 1'b1);
      expect_pulse("R10 count before tick decides");
   endtask

   task automatic t_gate();
      do_reset();
      for (int i = 0; i < 300; i++) begin
         cyc();
         if (rst_req_o !== 1'b0) chk("R3 idle cycles", rst_req_o, 0);
      end
      svc(mkword(2'b01, 1'b0, KEY), 1'b0);
      expect_pulse("R3 idle cycles not counted");
      do_reset();
      for (int i = 0; i < LOW - 1; i++) begin
         tick = 1'b1; cyc(); tick = 1'b0; cyc(); cyc(); cyc();
      end
      svc(mkword(2'b01, 1'b0, KEY), 1'b0);
      expect_pulse("R3 gated ticks below limit");
      do_reset();
      for (int i = 0; i < LOW; i++) begin
         tick = 1'b1; cyc(); tick = 1'b0; cyc(); cyc(); cyc();
      end
      svc(mkword(2'b11, 1'b1, KEY), 1'b0);
      chk("R3 gated ticks reach limit", rst_req_o, 0);
      chk("R3 window loaded", win_sel_o, 3);
   endtask

   initial begin
      t_reset();
      t_early();
      t_lower_edge();
      t_badkey();
      t_late();
      t_sel(2'b01);
      t_sel(2'b10);
      t_sel(2'b11);
      t_last();
      t_gate();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule